// File: doc/BRIEF.md
# Programmable-Strength BCH Parity Encoder

This block is a streaming systematic BCH encoder over GF(2^13) for protecting flash-sized data blocks. Message bits enter one per clock. Each accepted bit is forwarded unchanged and also divided by the generator polynomial of the chosen correction strength. After the final message bit, the remainder of that division follows at once as a run of parity bits. A later decoder needs the strength that encoded the block, so the block holds that strength on an output alongside the parity.

A block opens with a one-cycle start pulse that carries the requested strength t. Message bits follow with a data-valid qualifier, and a last marker goes with the final one. The legal strengths are 2, 4, 8, 10, 12, 14, 16, 18 and 20, and the parity length is 13·t bits. The generator polynomial for each strength is built at elaboration. It is the product of the distinct minimal polynomials of alpha^1, alpha^3, ..., alpha^(2t-1), in the field defined by x^13 + x^4 + x^3 + x + 1. No stored coefficient table is used.

Top module: `bch_parity_encoder`

## Requirements
- R1: While idle, a start pulse that carries a legal strength (2, 4, 8, 10, 12, 14, 16, 18 or 20) raises busy_o on the next cycle and sets used_strength_o to that strength.
- R2: A start pulse in idle that carries any other strength value (for example 0, 1, 3, 6, 22 or 31) raises strength_err_o for exactly one cycle and leaves busy_o low, so no block begins.
- R3: Every accepted message bit appears on code_bit_o one cycle later, unchanged, with code_valid_o=1 and code_par_o=0, in arrival order.
- R4: Directly after the last message bit, the block emits exactly 13·t parity bits with code_valid_o=1 and code_par_o=1 on consecutive cycles. par_end_o is high only on the final parity bit, and busy_o is low from that cycle on.
- R5: The emitted code word is read with its first bit as the highest-degree coefficient. Its syndromes S1, S3, ..., S(2t-1), evaluated in the field defined by x^13+x^4+x^3+x+1, are all zero. Flipping any single bit of the word makes at least one of S1 or S3 nonzero.
- R6: strength_i is sampled only at an accepted start. Changing it later has no effect on the block's parity, and used_strength_o keeps its value until the next accepted start.
- R7: A message ends after 8191−13·t bits even when last_i is never asserted, so the code word never exceeds 8191 bits.
- R8: start_i and data_valid_i are ignored while the block is emitting parity. data_valid_i is ignored in idle, and no output beat is produced.
- R9: Cycles with data_valid_i low inside a message leave the message and its parity unaffected.
- R10: Under synchronous reset, busy_o, code_valid_o, par_end_o and strength_err_o are 0, and used_strength_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a block while idle |
| strength_i | input | 5 | Requested correction strength t, sampled with start_i |
| data_valid_i | input | 1 | Qualifies data_i and last_i |
| data_i | input | 1 | Message bit |
| last_i | input | 1 | Marks the final message bit |
| busy_o | output | 1 | A block is in progress; new starts are not taken |
| code_valid_o | output | 1 | An output code bit is present |
| code_bit_o | output | 1 | Code word bit (message or parity) |
| code_par_o | output | 1 | The present code bit is parity |
| par_end_o | output | 1 | Final parity bit of the block |
| used_strength_o | output | 5 | Strength used for the current or most recent block |
| strength_err_o | output | 1 | One-cycle flag for a rejected strength |

## Verification
The bench builds the block with its package defaults: a 13-bit field, nine strength levels and a 260-bit division register. With these values, every legal strength can be run against a 4096-bit message. A message can also run to the full 8191-bit word length, which exercises the forced-end counter at t=20 and at t=2. Because the field size is the real one, the bench can evaluate the odd syndromes of each produced word directly in GF(2^13). That check covers all nine generator polynomials, not a reduced stand-in.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

    localparam int GF_M    = 13;
    localparam int GF_N    = (1 << GF_M) - 1;
    localparam logic [GF_M:0] GF_POLY = 14'h201B;
    localparam int NUM_LVL = 9;
    localparam int STR_W   = 5;
    localparam int LVL_W   = $clog2(NUM_LVL);

    // strength for level index: 2,4,8,10,...,20
    function automatic int lvl_strength(int i);
        return (i < 2) ? 2 * (i + 1) : 2 * i + 4;
    endfunction

    localparam int T_MAX  = lvl_strength(NUM_LVL - 1);
    localparam int PAR_W  = GF_M * T_MAX;
    localparam int PCNT_W = $clog2(PAR_W + 1);
    localparam int MCNT_W = $clog2(GF_N + 1);

    typedef logic [GF_M-1:0]  gf_t;
    typedef logic [PAR_W-1:0] rem_t;

    typedef enum logic [1:0] {ST_IDLE, ST_MSG, ST_PAR} enc_state_e;

    typedef struct packed {
        logic valid;
        logic dbit;
        logic par;
        logic last;
    } code_beat_s;

    typedef struct packed {
        logic             ok;
        logic [LVL_W-1:0] lvl;
    } lvl_dec_s;

    function automatic lvl_dec_s decode_strength(logic [STR_W-1:0] s);
        lvl_dec_s d;
        d = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (s == STR_W'(lvl_strength(i))) begin
                d.ok  = 1'b1;
                d.lvl = LVL_W'(i);
            end
        end
        return d;
    endfunction

    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t x;
        acc = '0;
        x   = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) acc = acc ^ x;
            if (x[GF_M-1]) x = (x << 1) ^ GF_POLY[GF_M-1:0];
            else           x = x << 1;
        end
        return acc;
    endfunction

    function automatic gf_t gf_pow(int e);
        gf_t r;
        gf_t base;
        int  ee;
        r    = gf_t'(1);
        base = gf_t'(2);
        ee   = e % GF_N;
        for (int k = 0; k < GF_M; k++) begin
            if (((ee >> k) & 1) == 1) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // odd exponent i starts a new conjugacy class if no conjugate is smaller
    function automatic bit is_leader(int i);
        int c;
        c = i;
        for (int k = 1; k < GF_M; k++) begin
            c = (c * 2) % GF_N;
            if (c < i) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int gen_deg(int t);
        int d;
        d = 0;
        for (int i = 1; i < 2 * t; i += 2)
            if (is_leader(i)) d += GF_M;
        return d;
    endfunction

    function automatic logic [PAR_W:0] gen_full(int t);
        logic [PAR_W:0] g;
        logic [PAR_W:0] ng;
        gf_t            p [0:GF_M];
        gf_t            root;
        int             c;
        g = (PAR_W+1)'(1);
        for (int i = 1; i < 2 * t; i += 2) begin
            if (is_leader(i)) begin
                for (int j = 0; j <= GF_M; j++) p[j] = '0;
                p[0] = gf_t'(1);
                c = i;
                for (int k = 0; k < GF_M; k++) begin
                    root = gf_pow(c);
                    for (int j = GF_M; j >= 1; j--)
                        p[j] = p[j-1] ^ gf_mul(p[j], root);
                    p[0] = gf_mul(p[0], root);
                    c = (c * 2) % GF_N;
                end
                ng = '0;
                for (int j = 0; j <= GF_M; j++)
                    if (p[j][0]) ng = ng ^ (g << j);
                g = ng;
            end
        end
        return g;
    endfunction

    // low coefficients of g placed at the top of the division register
    function automatic rem_t gen_aligned(int t);
        logic [PAR_W:0] full;
        rem_t           a;
        int             d;
        full    = gen_full(t);
        d       = gen_deg(t);
        full[d] = 1'b0;
        a       = full[PAR_W-1:0];
        return a << (PAR_W - d);
    endfunction

endpackage

// File: rtl/bch_strength_map.sv
module bch_strength_map
    import bch_enc_pkg::*;
(
    input  logic [STR_W-1:0] strength,
    output lvl_dec_s         dec
);
    always_comb dec = decode_strength(strength);
endmodule

// File: rtl/bch_gen_table.sv
module bch_gen_table
    import bch_enc_pkg::*;
(
    input  logic [LVL_W-1:0]  lvl,
    output rem_t              gen,
    output logic [PCNT_W-1:0] pdeg,
    output logic [MCNT_W-1:0] kmax
);
    rem_t              gen_tab  [NUM_LVL];
    logic [PCNT_W-1:0] deg_tab  [NUM_LVL];
    logic [MCNT_W-1:0] kmax_tab [NUM_LVL];

    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        localparam int   T_I   = lvl_strength(i);
        localparam int   DEG_I = gen_deg(T_I);
        localparam rem_t GEN_I = gen_aligned(T_I);
        assign gen_tab[i]  = GEN_I;
        assign deg_tab[i]  = PCNT_W'(DEG_I);
        assign kmax_tab[i] = MCNT_W'(GF_N - DEG_I);
    end

    always_comb begin
        gen  = gen_tab[0];
        pdeg = deg_tab[0];
        kmax = kmax_tab[0];
        for (int i = 1; i < NUM_LVL; i++) begin
            if (lvl == LVL_W'(i)) begin
                gen  = gen_tab[i];
                pdeg = deg_tab[i];
                kmax = kmax_tab[i];
            end
        end
    end
endmodule

// File: rtl/bch_div_reg.sv
module bch_div_reg
    import bch_enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step_msg,
    input  logic step_par,
    input  logic din,
    input  rem_t gen,
    output logic top
);
    rem_t rem_q;
    logic fb;

    assign top = rem_q[PAR_W-1];
    assign fb  = din ^ rem_q[PAR_W-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rem_q <= '0;
        end else if (step_msg) begin
            rem_q <= (rem_q << 1) ^ (fb ? gen : '0);
        end else if (step_par) begin
            rem_q <= rem_q << 1;
        end
    end
endmodule

// File: rtl/bch_parity_encoder.sv
module bch_parity_encoder
    import bch_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [STR_W-1:0] strength_i,
    input  logic             data_valid_i,
    input  logic             data_i,
    input  logic             last_i,
    output logic             busy_o,
    output logic             code_valid_o,
    output logic             code_bit_o,
    output logic             code_par_o,
    output logic             par_end_o,
    output logic [STR_W-1:0] used_strength_o,
    output logic             strength_err_o
);
    enc_state_e        st_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [MCNT_W-1:0] mcnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [STR_W-1:0]  used_q;
    logic              err_q;
    code_beat_s        beat_q;
    code_beat_s        beat_d;

    lvl_dec_s          dec;
    rem_t              gen_sel;
    logic [PCNT_W-1:0] pdeg;
    logic [MCNT_W-1:0] kmax;
    logic              rem_top;
    logic              do_clear;
    logic              do_msg;
    logic              do_par;
    logic              msg_end;

    bch_strength_map u_map (
        .strength (strength_i),
        .dec      (dec)
    );

    bch_gen_table u_tab (
        .lvl  (lvl_q),
        .gen  (gen_sel),
        .pdeg (pdeg),
        .kmax (kmax)
    );

    bch_div_reg u_div (
        .clk      (clk),
        .rst      (rst),
        .clear    (do_clear),
        .step_msg (do_msg),
        .step_par (do_par),
        .din      (data_i),
        .gen      (gen_sel),
        .top      (rem_top)
    );

    always_comb begin
        do_clear     = (st_q == ST_IDLE) && start_i && dec.ok;
        do_msg       = (st_q == ST_MSG) && data_valid_i;
        do_par       = (st_q == ST_PAR);
        msg_end      = do_msg && (last_i ||
                       (({1'b0, mcnt_q} + 1'b1) == {1'b0, kmax}));
        beat_d.valid = do_msg || do_par;
        beat_d.dbit  = do_par ? rem_top : data_i;
        beat_d.par   = do_par;
        beat_d.last  = do_par && (pcnt_q == PCNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            lvl_q  <= '0;
            mcnt_q <= '0;
            pcnt_q <= '0;
            used_q <= '0;
            err_q  <= 1'b0;
            beat_q <= '0;
        end else begin
            err_q  <= 1'b0;
            beat_q <= beat_d;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (dec.ok) begin
                            st_q   <= ST_MSG;
                            lvl_q  <= dec.lvl;
                            used_q <= strength_i;
                            mcnt_q <= '0;
                        end else begin
                            err_q  <= 1'b1;
                        end
                    end
                end
                ST_MSG: begin
                    if (do_msg) begin
                        mcnt_q <= mcnt_q + 1'b1;
                        if (msg_end) begin
                            st_q   <= ST_PAR;
                            pcnt_q <= pdeg;
                        end
                    end
                end
                ST_PAR: begin
                    pcnt_q <= pcnt_q - 1'b1;
                    if (pcnt_q == PCNT_W'(1)) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o          = (st_q != ST_IDLE);
    assign code_valid_o    = beat_q.valid;
    assign code_bit_o      = beat_q.dbit;
    assign code_par_o      = beat_q.par;
    assign par_end_o       = beat_q.last;
    assign used_strength_o = used_q;
    assign strength_err_o  = err_q;
endmodule

// File: rtl/bch_parity_encoder_chk.sv
module bch_parity_encoder_chk
    import bch_enc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [STR_W-1:0] strength_i,
    input logic             busy_o,
    input logic             code_valid_o,
    input logic             code_par_o,
    input logic             par_end_o,
    input logic [STR_W-1:0] used_strength_o,
    input logic             strength_err_o
);
    logic start_legal;
    always_comb start_legal = decode_strength(strength_i).ok;

    a_r1_legal_start_opens: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && start_legal)
        |=> (busy_o && used_strength_o == $past(strength_i)));

    a_r2_err_keeps_idle: assert property (@(posedge clk) disable iff (rst)
        strength_err_o |-> (!busy_o && $past(start_i) && !$past(busy_o)));

    a_r2_err_single_cycle: assert property (@(posedge clk) disable iff (rst)
        strength_err_o |=> !strength_err_o);

    a_r4_end_is_parity: assert property (@(posedge clk) disable iff (rst)
        par_end_o |-> (code_valid_o && code_par_o && !busy_o));

    a_r4_parity_contiguous: assert property (@(posedge clk) disable iff (rst)
        (code_valid_o && code_par_o && !par_end_o) |=> (code_valid_o && code_par_o));

    a_r6_strength_held: assert property (@(posedge clk) disable iff (rst)
        !$rose(busy_o) |-> $stable(used_strength_o));

    a_r8_no_beat_when_idle: assert property (@(posedge clk) disable iff (rst)
        code_valid_o |-> (busy_o || par_end_o));
endmodule

bind bch_parity_encoder bch_parity_encoder_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .start_i         (start_i),
    .strength_i      (strength_i),
    .busy_o          (busy_o),
    .code_valid_o    (code_valid_o),
    .code_par_o      (code_par_o),
    .par_end_o       (par_end_o),
    .used_strength_o (used_strength_o),
    .strength_err_o  (strength_err_o)
);

// File: tb/bch_parity_encoder_bench.sv
module bch_parity_encoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NMAX       = 8191;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [4:0] strength_i = '0;
    logic       data_valid_i = 1'b0;
    logic       data_i = 1'b0;
    logic       last_i = 1'b0;
    logic       busy_o, code_valid_o, code_bit_o, code_par_o, par_end_o, strength_err_o;
    logic [4:0] used_strength_o;

    bch_parity_encoder u_bch_parity_encoder (
        .clk(clk), .rst(rst), .start_i(start_i), .strength_i(strength_i),
        .data_valid_i(data_valid_i), .data_i(data_i), .last_i(last_i),
        .busy_o(busy_o), .code_valid_o(code_valid_o), .code_bit_o(code_bit_o),
        .code_par_o(code_par_o), .par_end_o(par_end_o),
        .used_strength_o(used_strength_o), .strength_err_o(strength_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    bit msg [0:NMAX];
    bit cw  [0:NMAX];
    bit cpar[0:NMAX];
    int cw_n = 0;
    int end_cnt = 0;

    always @(negedge clk) begin
        if (!rst && code_valid_o && cw_n <= NMAX) begin
            cw[cw_n]   = code_bit_o;
            cpar[cw_n] = code_par_o;
            if (par_end_o) end_cnt++;
            cw_n++;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // field arithmetic, MSB-first reduction by x^13+x^4+x^3+x+1
    function automatic logic [12:0] bmul(logic [12:0] a, logic [12:0] b);
        logic [12:0] r;
        r = '0;
        for (int k = 12; k >= 0; k--) begin
            if (r[12]) r = {r[11:0], 1'b0} ^ 13'h001B;
            else       r = {r[11:0], 1'b0};
            if (b[k]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [12:0] bpow(int j);
        logic [12:0] r;
        r = 13'd1;
        for (int k = 0; k < j; k++) r = bmul(r, 13'd2);
        return r;
    endfunction

    // Horner evaluation of the received word at alpha^j, optional flipped index
    function automatic logic [12:0] synd(int j, int n, int flip);
        logic [12:0] s;
        logic [12:0] aj;
        aj = bpow(j);
        s  = '0;
        for (int i = 0; i < n; i++)
            s = bmul(s, aj) ^ {12'd0, cw[i] ^ (i == flip)};
        return s;
    endfunction

    function automatic int legal_t(int idx);
        return (idx < 2) ? 2 * (idx + 1) : 2 * idx + 4;
    endfunction

    task automatic run_block(int t, int n_drive, bit use_last, int gap, bit disturb);
        int k_exp, n_exp, mism, bad_par, guard, nz, pos;
        logic [12:0] s1, s3;
        k_exp = use_last ? n_drive : ((n_drive < NMAX - 13*t) ? n_drive : NMAX - 13*t);
        n_exp = k_exp + 13*t;
        for (int i = 0; i < n_drive; i++) msg[i] = bit'($urandom & 1);
        cw_n = 0;
        end_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; strength_i = 5'(t);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1", "busy after legal start", busy_o, 1);
        chk(used_strength_o == 5'(t), "R1", "used strength", used_strength_o, t);
        if (disturb) strength_i = 5'($urandom);
        for (int i = 0; i < n_drive; i++) begin
            while (gap > 0 && ($urandom % gap) == 0) begin
                data_valid_i = 1'b0;
                data_i = bit'($urandom & 1);
                last_i = bit'($urandom & 1);
                if (disturb) begin start_i = 1'b1; strength_i = 5'd4; end
                @(negedge clk);
                start_i = 1'b0;
            end
            data_valid_i = 1'b1;
            data_i = msg[i];
            last_i = use_last && (i == n_drive - 1);
            @(negedge clk);
        end
        data_valid_i = 1'b0;
        last_i = 1'b0;
        if (disturb) begin
            for (int i = 0; i < 3; i++) begin
                start_i = 1'b1; strength_i = 5'd4;
                data_valid_i = 1'b1; data_i = 1'b1; last_i = 1'b1;
                @(negedge clk);
            end
            start_i = 1'b0; data_valid_i = 1'b0; last_i = 1'b0;
        end
        guard = 0;
        while (busy_o && guard < 20000) begin @(negedge clk); guard++; end
        @(negedge clk);
        chk(busy_o == 1'b0, "R4", "idle after parity", busy_o, 0);
        chk(cw_n == n_exp, "R4", "code word length", cw_n, n_exp);
        chk(end_cnt == 1, "R4", "parity end strobes", end_cnt, 1);
        if (cw_n == n_exp) begin
            mism = 0; bad_par = 0;
            for (int i = 0; i < n_exp; i++) begin
                if (i < k_exp && cw[i] != msg[i]) mism++;
                if (cpar[i] != (i >= k_exp)) bad_par++;
            end
            chk(mism == 0, "R3", "message bits passed through", mism, 0);
            chk(bad_par == 0, "R4", "parity flag placement", bad_par, 0);
            if (!use_last)
                chk(k_exp == NMAX - 13*t, "R7", "forced message length", k_exp, NMAX - 13*t);
            nz = 0;
            for (int j = 1; j < 2*t; j += 2)
                if (synd(j, n_exp, -1) != 13'd0) nz++;
            chk(nz == 0, "R5", "nonzero syndromes", nz, 0);
            for (int f = 0; f < 2; f++) begin
                pos = (f == 0) ? n_exp - 1 : int'($urandom % n_exp);
                s1 = synd(1, n_exp, pos);
                s3 = synd(3, n_exp, pos);
                chk(s1 != 13'd0 || s3 != 13'd0, "R5", "single flip detected", int'(s1), -1);
            end
        end
        chk(used_strength_o == 5'(t), "R6", "strength held after block", used_strength_o, t);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_fail++;
                n_chk++;
                $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
                report();
            end
        end
    end

    initial begin
        int cnt0;
        int bad [6];
        void'($urandom(32'd20240611));
        bad[0] = 0; bad[1] = 1; bad[2] = 3; bad[3] = 6; bad[4] = 22; bad[5] = 31;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(busy_o == 1'b0, "R10", "busy after reset", busy_o, 0);
        chk(code_valid_o == 1'b0, "R10", "code_valid after reset", code_valid_o, 0);
        chk(par_end_o == 1'b0, "R10", "par_end after reset", par_end_o, 0);
        chk(strength_err_o == 1'b0, "R10", "err after reset", strength_err_o, 0);
        chk(used_strength_o == 5'd0, "R10", "used strength after reset", used_strength_o, 0);

        // R8 data in idle ignored
        cw_n = 0;
        data_valid_i = 1'b1; data_i = 1'b1; last_i = 1'b1;
        repeat (5) @(negedge clk);
        data_valid_i = 1'b0; last_i = 1'b0;
        @(negedge clk);
        cnt0 = cw_n;
        chk(cnt0 == 0, "R8", "beats from idle data", cnt0, 0);
        chk(busy_o == 1'b0, "R8", "busy from idle data", busy_o, 0);

        // R2 illegal strengths
        foreach (bad[i]) begin
            start_i = 1'b1; strength_i = 5'(bad[i]);
            @(negedge clk);
            start_i = 1'b0;
            chk(strength_err_o == 1'b1, "R2", "error flag", strength_err_o, 1);
            chk(busy_o == 1'b0, "R2", "no block on bad strength", busy_o, 0);
            @(negedge clk);
            chk(strength_err_o == 1'b0, "R2", "error flag single cycle", strength_err_o, 0);
        end
        chk(used_strength_o == 5'd0, "R2", "strength untouched by bad start", used_strength_o, 0);

        // R1 R3 R4 R5 every legal strength, 512-byte message
        for (int l = 0; l < 9; l++) run_block(legal_t(l), 4096, 1'b1, 0, 1'b0);

        // R1 shortest message
        run_block(2, 1, 1'b1, 0, 1'b0);

        // R6 R8 R9 random lengths with bubbles and disturbances
        for (int r = 0; r < 8; r++)
            run_block(legal_t(int'($urandom % 9)), 1 + int'($urandom % 600), 1'b1, 3, 1'b1);

        // R7 forced end at the length limit
        run_block(20, NMAX - 260 + 2, 1'b0, 0, 1'b0);
        run_block(2, NMAX - 26 + 1, 1'b0, 0, 1'b0);

        done = 1'b1;
        report();
    end
endmodule